// File: doc/BRIEF.md
# Vectored Interrupt Source Router

The router takes six level-sensitive interrupt inputs and steers each one onto one of six output lines. Each input owns a 64-bit vector register that software programs with a target server, a priority and a source number. The source number chooses the output line. A priority of all ones masks the vector. Each vector also keeps a pending flag, which records whether its input was asserted and unmasked at the last input event.

Input 0 is the service-processor interrupt. It shares its line with a link interrupt flag that software holds in the control register. That line stays high while either contributor is set. Input 0 records its level in control bit 46. Inputs 1 to 5 record theirs in a read-only status register. Registers are written through a single-cycle write port and read back through a combinational read port. Addresses 0 to 5 select the vectors, 6 the control register and 7 the status register.

Top module: `isr_router`

## Requirements
- R1: After reset, vector i reads server 0, priority 0xFF (bits 39:32), source number i (bits 31:29) and pending 0 (bit 24). The control register, the status register and all output lines are 0.
- R2: Each input is registered once before it is evaluated. Its status bit therefore changes at the second rising edge after the input changes. Input 0 uses control bit 46, and input k (k = 1..5) uses status bit 37-k.
- R3: For k = 1..5, output line s is high while some input k that is asserted has source field s.
- R4: The line chosen by vector 0 is high while control bit 46 or control bit 47 is set. It falls only when both are clear. Writing bit 47 alone raises the line.
- R5: At each input event (a change of the registered level), the vector's pending bit (24) becomes 1 if its line is still asserted and its priority is not 0xFF. Otherwise it becomes 0.
- R6: A vector write whose new priority is 0xFF clears pending. A write with any other priority keeps the current pending bit.
- R7: A vector write stores only server (55:40), priority (39:32) and source (31:29). All other written bits are dropped and read back as 0, apart from the kept pending bit 24.
- R8: A vector write whose source field is 6 or 7 is rejected and leaves the register unchanged.
- R9: The effective target server of vector i is its server field shifted right by 2. It is presented on `eff_srv_o[i*14 +: 14]`.
- R10: Writes to the status register (address 7) have no effect.
- R11: A control-register write (address 6) stores all 64 bits. In the same cycle, an input-0 event overrides bit 46.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 6 | Level interrupt inputs, bit k is input k |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 64 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 64 | Read data, combinational |
| line_o | output | 6 | Output interrupt lines, one per source number |
| eff_srv_o | output | 84 | Effective target server per vector, 14 bits each |

## Verification
The assertions assume that every write address is one of the eight defined registers, and that interrupt inputs change only on the inactive clock edge. The stimulus therefore uses only addresses 0 to 7 and changes inputs and write strobes at the falling edge. The assertions also assume that a rejected vector write, and a write to the status register, do not coincide with an input event on the same register. The stimulus keeps the inputs quiet during those writes, so that register stability can be checked without interference.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int REG_W    = 64;
  localparam int SRV_LO   = 40;
  localparam int SRV_W    = 16;
  localparam int PRI_LO   = 32;
  localparam int PRI_W    = 8;
  localparam int SRC_LO   = 29;
  localparam int SRC_W    = 3;
  localparam int PEND_BIT = 24;
  localparam int CTL_OWN_BIT  = 46;
  localparam int CTL_LINK_BIT = 47;
  localparam int STAT_TOP_BIT = 37;
  localparam int ESRV_W   = SRV_W - 2;

  localparam logic [REG_W-1:0] FIELD_MASK =
    ({{(REG_W-SRV_W){1'b0}}, {SRV_W{1'b1}}} << SRV_LO) |
    ({{(REG_W-PRI_W){1'b0}}, {PRI_W{1'b1}}} << PRI_LO) |
    ({{(REG_W-SRC_W){1'b0}}, {SRC_W{1'b1}}} << SRC_LO);

  function automatic logic [SRV_W-1:0] get_srv(input logic [REG_W-1:0] v);
    return v[SRV_LO +: SRV_W];
  endfunction

  function automatic logic [PRI_W-1:0] get_pri(input logic [REG_W-1:0] v);
    return v[PRI_LO +: PRI_W];
  endfunction

  function automatic logic [SRC_W-1:0] get_src(input logic [REG_W-1:0] v);
    return v[SRC_LO +: SRC_W];
  endfunction

  function automatic logic is_masked(input logic [PRI_W-1:0] p);
    return &p;
  endfunction

  function automatic logic [ESRV_W-1:0] eff_server(input logic [SRV_W-1:0] s);
    return s[SRV_W-1:2];
  endfunction

  function automatic int stat_pos(input int k);
    return STAT_TOP_BIT - k;
  endfunction

  function automatic logic [REG_W-1:0] reset_vec(input int idx);
    logic [REG_W-1:0] v;
    v = '0;
    v[PRI_LO +: PRI_W] = '1;
    v[SRC_LO +: SRC_W] = SRC_W'(idx);
    return v;
  endfunction
endpackage

// File: rtl/isr_sync.sv
module isr_sync #(
  parameter int NIN = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NIN-1:0] irq_i,
  output logic [NIN-1:0] lvl_q,
  output logic [NIN-1:0] evt
);
  logic [NIN-1:0] lvl_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= '0;
      lvl_d <= '0;
    end else begin
      lvl_q <= irq_i;
      lvl_d <= lvl_q;
    end
  end

  assign evt = lvl_q ^ lvl_d;
endmodule

// File: rtl/isr_vec.sv
module isr_vec
  import isr_pkg::*;
#(
  parameter int IDX  = 0,
  parameter int NSRC = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             evt,
  input  logic             a_new,
  output logic [REG_W-1:0] vec,
  output logic [SRC_W-1:0] src,
  output logic             masked,
  output logic             pend,
  output logic [ESRV_W-1:0] esrv
);
  logic [REG_W-1:0] fields_q, fields_n;
  logic             pend_n, wr_ok, masked_n;

  always_comb begin
    wr_ok    = wr && (int'(get_src(wdata)) < NSRC);
    fields_n = wr_ok ? (wdata & FIELD_MASK) : fields_q;
    masked_n = is_masked(get_pri(fields_n));
    if (evt)           pend_n = a_new && !masked_n;
    else if (masked_n) pend_n = 1'b0;
    else               pend_n = pend;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fields_q <= reset_vec(IDX);
      pend     <= 1'b0;
    end else begin
      fields_q <= fields_n;
      pend     <= pend_n;
    end
  end

  always_comb begin
    vec = fields_q;
    vec[PEND_BIT] = pend;
  end

  assign src    = get_src(fields_q);
  assign masked = is_masked(get_pri(fields_q));
  assign esrv   = eff_server(get_srv(fields_q));
endmodule

// File: rtl/isr_line_map.sv
module isr_line_map
  import isr_pkg::*;
#(
  parameter int NSRC = 6
) (
  input  logic [NSRC-1:0]       asrt,
  input  logic [NSRC*SRC_W-1:0] src_flat,
  output logic [NSRC-1:0]       line
);
  for (genvar s = 0; s < NSRC; s++) begin : g_line
    logic [NSRC-1:0] hit;
    for (genvar k = 0; k < NSRC; k++) begin : g_in
      assign hit[k] = asrt[k] && (int'(src_flat[k*SRC_W +: SRC_W]) == s);
    end
    assign line[s] = |hit;
  end
endmodule

// File: rtl/isr_router.sv
module isr_router
  import isr_pkg::*;
#(
  parameter int NSRC = 6,
  parameter int AW   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          irq_i,
  input  logic                     wr_en_i,
  input  logic [AW-1:0]            wr_addr_i,
  input  logic [REG_W-1:0]         wr_data_i,
  input  logic [AW-1:0]            rd_addr_i,
  output logic [REG_W-1:0]         rd_data_o,
  output logic [NSRC-1:0]          line_o,
  output logic [NSRC*ESRV_W-1:0]   eff_srv_o
);
  localparam int A_CTL  = NSRC;
  localparam int A_STAT = NSRC + 1;

  logic [NSRC-1:0]       lvl_q, evt, a_new, asrt, masked, pend;
  logic [NSRC*SRC_W-1:0] src_flat;
  logic [REG_W-1:0]      vec [NSRC];
  logic [REG_W-1:0]      ctl_q, ctl_n, stat_q, stat_n;
  logic                  ctl_wr;

  isr_sync #(.NIN(NSRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .lvl_q(lvl_q), .evt(evt)
  );

  // line state now and line state after an event on that input
  always_comb begin
    for (int k = 0; k < NSRC; k++) begin
      if (k == 0) begin
        asrt[k]  = ctl_q[CTL_OWN_BIT] | ctl_q[CTL_LINK_BIT];
        a_new[k] = lvl_q[k] | ctl_q[CTL_LINK_BIT];
      end else begin
        asrt[k]  = stat_q[stat_pos(k)];
        a_new[k] = lvl_q[k];
      end
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_vec
    isr_vec #(.IDX(i), .NSRC(NSRC)) u_vec (
      .clk(clk), .rst_n(rst_n),
      .wr(wr_en_i && (int'(wr_addr_i) == i)),
      .wdata(wr_data_i),
      .evt(evt[i]), .a_new(a_new[i]),
      .vec(vec[i]),
      .src(src_flat[i*SRC_W +: SRC_W]),
      .masked(masked[i]), .pend(pend[i]),
      .esrv(eff_srv_o[i*ESRV_W +: ESRV_W])
    );
  end

  isr_line_map #(.NSRC(NSRC)) u_map (
    .asrt(asrt), .src_flat(src_flat), .line(line_o)
  );

  assign ctl_wr = wr_en_i && (int'(wr_addr_i) == A_CTL);

  always_comb begin
    ctl_n  = ctl_wr ? wr_data_i : ctl_q;
    stat_n = stat_q;
    if (evt[0]) ctl_n[CTL_OWN_BIT] = lvl_q[0];
    for (int k = 1; k < NSRC; k++)
      if (evt[k]) stat_n[stat_pos(k)] = lvl_q[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      stat_q <= '0;
    end else begin
      ctl_q  <= ctl_n;
      stat_q <= stat_n;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (int'(rd_addr_i) < NSRC)        rd_data_o = vec[rd_addr_i];
    else if (int'(rd_addr_i) == A_CTL) rd_data_o = ctl_q;
    else if (int'(rd_addr_i) == A_STAT) rd_data_o = stat_q;
  end
endmodule

// File: rtl/isr_router_chk.sv
module isr_router_chk
  import isr_pkg::*;
#(
  parameter int NSRC = 6,
  parameter int AW   = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NSRC-1:0]          evt,
  input logic [NSRC-1:0]          lvl_q,
  input logic [NSRC-1:0]          a_new,
  input logic [NSRC-1:0]          masked,
  input logic [NSRC-1:0]          pend,
  input logic [NSRC*SRC_W-1:0]    src_flat,
  input logic [REG_W-1:0]         ctl_q,
  input logic [REG_W-1:0]         stat_q,
  input logic                     wr_en_i,
  input logic [AW-1:0]            wr_addr_i,
  input logic [REG_W-1:0]         wr_data_i,
  input logic [NSRC-1:0]          line_o
);
  logic [SRC_W-1:0] src0;
  assign src0 = src_flat[SRC_W-1:0];

  // R4
  link_holds_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[CTL_LINK_BIT] |-> line_o[src0]);

  // R2
  own_bit_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt[0] |=> ctl_q[CTL_OWN_BIT] == $past(lvl_q[0]));

  // R10
  stat_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && int'(wr_addr_i) == NSRC + 1 && evt == '0) |=> $stable(stat_q));

  for (genvar k = 0; k < NSRC; k++) begin : g_k
    logic wr_k;
    assign wr_k = wr_en_i && (int'(wr_addr_i) == k);

    // R6
    masked_not_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      masked[k] |-> !pend[k]);

    // R5
    event_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[k] && !wr_k) |=> pend[k] == $past(a_new[k] && !masked[k]));

    // R8
    bad_src_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_k && int'(wr_data_i[SRC_LO +: SRC_W]) >= NSRC && !evt[k])
        |=> $stable(src_flat[k*SRC_W +: SRC_W]) && $stable(masked[k]) && $stable(pend[k]));

    if (k > 0) begin : g_stat
      // R2
      stat_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt[k] |=> stat_q[stat_pos(k)] == $past(lvl_q[k]));
    end
  end
endmodule

bind isr_router isr_router_chk #(.NSRC(NSRC), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt(evt), .lvl_q(lvl_q), .a_new(a_new),
  .masked(masked), .pend(pend), .src_flat(src_flat), .ctl_q(ctl_q),
  .stat_q(stat_q), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .line_o(line_o)
);

// File: tb/sim_isr_router.sv
`timescale 1ns/1ps
module sim_isr_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  irq_i = '0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [63:0] wr_data_i = '0;
  logic [2:0]  rd_addr_i = '0;
  logic [63:0] rd_data_o;
  logic [5:0]  line_o;
  logic [83:0] eff_srv_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  isr_router u0 (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .line_o(line_o), .eff_srv_o(eff_srv_o)
  );

  localparam logic [63:0] B47 = 64'h0000_8000_0000_0000;
  localparam logic [63:0] B46 = 64'h0000_4000_0000_0000;
  localparam logic [63:0] PND = 64'h0000_0000_0100_0000;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] d);
    rd_addr_i = a;
    #0.5;
    d = rd_data_o;
  endtask

  task automatic set_irq(input int k, input logic v);
    @(negedge clk);
    irq_i[k] = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [63:0] d;
    for (int i = 0; i < 6; i++) begin
      rd(3'(i), d);
      check("R1 vector reset", d, (64'hFF << 32) | (64'(i) << 29));
    end
    rd(3'd6, d); check("R1 control reset", d, 64'h0);
    rd(3'd7, d); check("R1 status reset", d, 64'h0);
    check("R1 lines reset", 64'(line_o), 64'h0);
  endtask

  task automatic t_route();
    logic [63:0] d;
    wr(3'd1, 64'h0012_3405_6000_0000);
    rd(3'd1, d); check("R7 vector1 write", d, 64'h0012_3405_6000_0000);
    check("R9 eff server vec1", 64'(eff_srv_o[14 +: 14]), 64'h48D);
    @(negedge clk); irq_i[1] = 1'b1;
    @(negedge clk);
    rd(3'd7, d); check("R2 status latency one edge", d, 64'h0);
    @(negedge clk);
    rd(3'd7, d); check("R2 status bit 36", d, 64'h0000_0010_0000_0000);
    check("R3 line 3 routed", 64'(line_o), 64'h08);
    rd(3'd1, d); check("R5 pending set", d, 64'h0012_3405_6000_0000 | PND);
    set_irq(1, 1'b0);
    check("R3 line dropped", 64'(line_o), 64'h0);
    rd(3'd1, d); check("R5 pending cleared", d, 64'h0012_3405_6000_0000);
  endtask

  task automatic t_mask();
    logic [63:0] d;
    set_irq(1, 1'b1);
    wr(3'd1, 64'h0012_3409_6000_0000);
    rd(3'd1, d); check("R6 unmasked write keeps pending", d, 64'h0012_3409_6000_0000 | PND);
    wr(3'd1, 64'h0012_34FF_6000_0000);
    rd(3'd1, d); check("R6 masked write clears pending", d, 64'h0012_34FF_6000_0000);
    check("R3 masked line still high", 64'(line_o), 64'h08);
    set_irq(1, 1'b0);
    set_irq(2, 1'b1);
    rd(3'd7, d); check("R2 status bit 35", d, 64'h0000_0008_0000_0000);
    check("R3 default route line 2", 64'(line_o), 64'h04);
    rd(3'd2, d); check("R5 masked no pending", d, (64'hFF << 32) | (64'd2 << 29));
    set_irq(2, 1'b0);
  endtask

  task automatic t_shared();
    logic [63:0] d;
    wr(3'd0, 64'h0000_0003_0000_0000);
    wr(3'd6, B47);
    check("R4 link bit raises line", 64'(line_o), 64'h01);
    rd(3'd6, d); check("R11 control stored", d, B47);
    set_irq(0, 1'b1);
    rd(3'd6, d); check("R2 control bit 46", d, B47 | B46);
    rd(3'd0, d); check("R5 pending vec0", d, 64'h0000_0003_0000_0000 | PND);
    set_irq(0, 1'b0);
    rd(3'd6, d); check("R2 bit 46 cleared", d, B47);
    check("R4 line held by link", 64'(line_o), 64'h01);
    rd(3'd0, d); check("R5 pending held by link", d, 64'h0000_0003_0000_0000 | PND);
    wr(3'd6, 64'h0);
    check("R4 line drops when both clear", 64'(line_o), 64'h0);
    set_irq(0, 1'b1);
    check("R4 line from input 0", 64'(line_o), 64'h01);
    set_irq(0, 1'b0);
    check("R4 line falls", 64'(line_o), 64'h0);
    rd(3'd0, d); check("R5 pending cleared vec0", d, 64'h0000_0003_0000_0000);
    // R11: event on input 0 overrides bit 46 of a same-cycle write
    @(negedge clk); irq_i[0] = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = 3'd6; wr_data_i = 64'h0000_0000_0000_00A5;
    @(negedge clk); wr_en_i = 1'b0;
    rd(3'd6, d); check("R11 event overrides bit 46", d, B46 | 64'hA5);
    set_irq(0, 1'b0);
    wr(3'd6, 64'h0);
  endtask

  task automatic t_fields();
    logic [63:0] d;
    wr(3'd3, 64'hFFFF_FFFE_7FFF_FFFF);
    rd(3'd3, d); check("R7 only fields stored", d, 64'h00FF_FFFE_6000_0000);
    check("R9 eff server vec3", 64'(eff_srv_o[42 +: 14]), 64'h3FFF);
  endtask

  task automatic t_bad_src();
    logic [63:0] d;
    wr(3'd4, 64'h0000_0001_C000_0000);
    rd(3'd4, d); check("R8 source 6 rejected", d, 64'h0000_00FF_8000_0000);
    wr(3'd4, 64'h0000_0001_E000_0000);
    rd(3'd4, d); check("R8 source 7 rejected", d, 64'h0000_00FF_8000_0000);
  endtask

  task automatic t_stat_ro();
    logic [63:0] d;
    wr(3'd7, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(3'd7, d); check("R10 status write ignored", d, 64'h0);
    check("R10 lines unaffected", 64'(line_o), 64'h0);
  endtask

  task automatic t_server();
    wr(3'd5, 64'h0000_0701_A000_0000);
    check("R9 server 7 gives 1", 64'(eff_srv_o[70 +: 14]), 64'h1);
    wr(3'd5, 64'h00AB_CD01_A000_0000);
    check("R9 server ABCD", 64'(eff_srv_o[70 +: 14]), 64'h2AF3);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_route();
    t_mask();
    t_shared();
    t_fields();
    t_bad_src();
    t_stat_ro();
    t_server();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule